// File: doc/BRIEF.md
# Audio Serial Bit-Clock and Word-Select Generator

This block divides an audio master clock down to the two timing signals a serial audio link needs: a bit clock and a left/right word-select clock. Both have a 50% duty cycle. A 6-bit bit divider sets the bit-clock half-period in master-clock cycles. A 6-bit word divider sets the word-select half-period in bit-clock periods. Because the word select is built from the bit clock, the two outputs are always locked together in frequency.

Two phase controls set the timing edges. The bit-clock phase bit chooses whether the outputs move on the rising or the falling edge of the master clock. The word-select phase bit chooses whether the word select moves on the rising or the falling edge of the bit clock.

New divider values are picked up only at the end of the half-period in progress. A word divider of zero is treated as one. This keeps both outputs free of runt pulses and stops the word select from ever stalling.

Top module: `audio_serial_clkgen`

## Requirements
- R1: The bit clock stays in each level for exactly bdiv_cfg+1 master-clock cycles, so its period is 2·(bdiv_cfg+1) master cycles.
- R2: The word select stays in each level for exactly wdiv_cfg bit-clock periods, which is 2·(bdiv_cfg+1)·wdiv_cfg master cycles.
- R3: With bclk_phase=1 both outputs change on the rising edge of the master clock. With bclk_phase=0 they change on the falling edge of the master clock.
- R4: Every word-select change coincides with a bit-clock change. The bit clock's new value equals ws_phase: 1 means its rising edge, 0 means its falling edge.
- R5: wdiv_cfg=0 gives the same word-select timing as wdiv_cfg=1, that is a half-period of one bit-clock period.
- R6: A divider value changed during a half-period does not alter that half-period. It applies from the next half-period on.
- R7: While rst is high at a master-clock rising edge, both outputs are driven low and both counters restart from zero.
- R8: For the settings (bdiv 3, wdiv 16), (bdiv 7, wdiv 8) and (bdiv 1, wdiv 32), the word-select period is 256 master cycles. This gives 48 kHz from 12.288 MHz and 44.1 kHz from 11.2896 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Audio master clock |
| rst | input | 1 | Synchronous reset, active high |
| bdiv_cfg | input | 6 | Bit-clock divider value |
| wdiv_cfg | input | 6 | Word-select divider value |
| bclk_phase | input | 1 | 1: outputs move on the master rising edge; 0: on the master falling edge |
| ws_phase | input | 1 | 1: word select moves with the bit clock's rising edge; 0: with its falling edge |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word-select clock |

## Verification
The assertions assume the two phase bits stay constant while the block runs. A phase change outside reset would swap the output path partway through a half-period. The assertions also assume the divider inputs are registered values in the master-clock domain. The stimulus follows both rules: it changes the phase bits only while reset is held. It changes divider values only away from clock edges, and also in the middle of a half-period, to exercise the deferred pickup.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
   localparam int unsigned DIV_W_MIN = 2;
   localparam int unsigned DIV_W_MAX = 16;

   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } edge_e;
endpackage

// File: rtl/bclk_divider.sv
module bclk_divider #(
   parameter int unsigned DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DIV_W-1:0] div_cfg,
   output logic             bclk_p,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] lim_q;

   // terminal count ends the current half-period
   assign tick = (cnt_q == lim_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         lim_q  <= div_cfg;
         bclk_p <= 1'b0;
      end else if (tick) begin
         cnt_q  <= '0;
         lim_q  <= div_cfg;
         bclk_p <= ~bclk_p;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= lim_q)
      else $error("bit counter beyond limit");

   p_limit_held_r6: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(lim_q))
      else $error("bit limit reloaded mid half-period");

   p_level_held_r1: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(bclk_p))
      else $error("bit clock moved before terminal count");

   p_reset_clear_r7: assert property (@(posedge clk)
      rst |=> (!bclk_p && cnt_q == '0))
      else $error("reset did not clear bit divider");
endmodule

// File: rtl/wsel_divider.sv
module wsel_divider #(
   parameter int unsigned DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DIV_W-1:0] div_cfg,
   input  logic             edge_sel,
   input  logic             b_tick,
   input  logic             b_now,
   output logic             wsel_p
);
   import audclk_pkg::*;

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] lim_q;
   logic [DIV_W-1:0] lim_safe;
   logic             b_event;
   logic             w_tick;
   edge_e            want_edge;

   // zero would stall the output; it is promoted to one
   assign lim_safe  = (div_cfg == '0) ? DIV_W'(1) : div_cfg;
   assign want_edge = edge_e'(edge_sel);
   // the bit clock is about to take the selected new level
   assign b_event   = b_tick && (edge_e'(~b_now) == want_edge);
   assign w_tick    = b_event && (cnt_q == lim_q - 1'b1);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         lim_q  <= lim_safe;
         wsel_p <= 1'b0;
      end else if (w_tick) begin
         cnt_q  <= '0;
         lim_q  <= lim_safe;
         wsel_p <= ~wsel_p;
      end else if (b_event) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   p_limit_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
      lim_q != '0)
      else $error("word limit is zero");

   p_cnt_below_limit_r2: assert property (@(posedge clk) disable iff (rst)
      cnt_q < lim_q)
      else $error("word counter beyond limit");

   p_limit_held_r6: assert property (@(posedge clk) disable iff (rst)
      !w_tick |=> $stable(lim_q))
      else $error("word limit reloaded mid half-period");

   p_reset_clear_r7: assert property (@(posedge clk)
      rst |=> (!wsel_p && cnt_q == '0))
      else $error("reset did not clear word divider");
endmodule

// File: rtl/phase_retime.sv
module phase_retime #(
   parameter int unsigned W       = 2,
   parameter bit          FALL_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         sel_rise,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (FALL_EN) begin : g_fall
         logic [W-1:0] q_n;

         // half-cycle delay moves the change onto the falling edge
         always_ff @(negedge clk) begin
            if (rst) q_n <= '0;
            else     q_n <= d;
         end

         assign q = sel_rise ? d : q_n;

         p_fall_lag_r3: assert property (@(posedge clk) disable iff (rst)
            !sel_rise |-> (q_n == d))
            else $error("falling-edge copy out of step");
      end else begin : g_rise_only
         assign q = d;
      end
   endgenerate
endmodule

// File: rtl/audio_serial_clkgen.sv
module audio_serial_clkgen #(
   parameter int unsigned DIV_W   = 6,
   parameter bit          FALL_EN = 1'b1
) (
   input  logic             mclk,
   input  logic             rst,
   input  logic [DIV_W-1:0] bdiv_cfg,
   input  logic [DIV_W-1:0] wdiv_cfg,
   input  logic             bclk_phase,
   input  logic             ws_phase,
   output logic             bclk_o,
   output logic             ws_o
);
   import audclk_pkg::*;

   localparam int unsigned OUT_W = 2;

   generate
      if (DIV_W < DIV_W_MIN || DIV_W > DIV_W_MAX) begin : g_bad_width
         $error("DIV_W outside supported range");
      end
   endgenerate

   logic             bclk_p;
   logic             b_tick;
   logic             wsel_p;
   logic [OUT_W-1:0] out_q;

   bclk_divider #(.DIV_W(DIV_W)) u_bdiv (
      .clk     (mclk),
      .rst     (rst),
      .div_cfg (bdiv_cfg),
      .bclk_p  (bclk_p),
      .tick    (b_tick)
   );

   wsel_divider #(.DIV_W(DIV_W)) u_wdiv (
      .clk      (mclk),
      .rst      (rst),
      .div_cfg  (wdiv_cfg),
      .edge_sel (ws_phase),
      .b_tick   (b_tick),
      .b_now    (bclk_p),
      .wsel_p   (wsel_p)
   );

   phase_retime #(.W(OUT_W), .FALL_EN(FALL_EN)) u_retime (
      .clk      (mclk),
      .rst      (rst),
      .sel_rise (bclk_phase),
      .d        ({wsel_p, bclk_p}),
      .q        (out_q)
   );

   assign bclk_o = out_q[0];
   assign ws_o   = out_q[1];

   p_ws_on_bclk_edge_r4: assert property (@(posedge mclk) disable iff (rst)
      !$stable(wsel_p) |-> (!$stable(bclk_p) && bclk_p == $past(ws_phase)))
      else $error("word select moved off the chosen bit-clock edge");
endmodule

// File: tb/audio_serial_clkgen_test.sv
`timescale 1ns/1ps
module audio_serial_clkgen_test;
   logic       mclk = 1'b0;
   logic       rst  = 1'b1;
   logic [5:0] bdiv = 6'd3;
   logic [5:0] wdiv = 6'd16;
   logic       bp   = 1'b1;
   logic       wp   = 1'b1;
   logic       bclk;
   logic       ws;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   int unsigned qb[$];
   int unsigned qw[$];
   string tag_b = "R1";
   string tag_w = "R2";
   bit    chk_ph = 0;

   event b_tog;
   event w_tog;

   always #10 mclk = ~mclk;

   audio_serial_clkgen uut (
      .mclk(mclk), .rst(rst), .bdiv_cfg(bdiv), .wdiv_cfg(wdiv),
      .bclk_phase(bp), .ws_phase(wp), .bclk_o(bclk), .ws_o(ws)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // ---------------- monitor ----------------
   int  slot = 0;
   int  b_last, w_last;
   bit  have_b = 0, have_w = 0;
   logic prev_b = 0, prev_w = 0;

   task automatic sample(input int kind);
      bit b_chg;
      slot++;
      b_chg = 0;
      if (rst) begin
         have_b = 0; have_w = 0;
         prev_b = bclk; prev_w = ws;
         return;
      end
      if (bclk !== prev_b) begin
         b_chg = 1;
         if (have_b && qb.size() > 0) begin
            int unsigned e = qb.pop_front();
            check((slot - b_last) / 2 == e, tag_b, (slot - b_last) / 2, e);
         end
         if (chk_ph) // R3: edge slot 0 = after rising edge, 1 = after falling edge
            check(kind == (bp ? 0 : 1), "R3", kind, bp ? 0 : 1);
         b_last = slot; have_b = 1; prev_b = bclk;
         -> b_tog;
      end
      if (ws !== prev_w) begin
         if (chk_ph) begin // R4: coincides with bit-clock edge of chosen polarity
            check(b_chg, "R4", b_chg, 1);
            check(bclk == wp, "R4", bclk, wp);
         end
         if (have_w && qw.size() > 0) begin
            int unsigned e = qw.pop_front();
            check((slot - w_last) / 2 == e, tag_w, (slot - w_last) / 2, e);
         end
         w_last = slot; have_w = 1; prev_w = ws;
         -> w_tog;
      end
   endtask

   initial begin
      forever begin
         @(posedge mclk); #5 sample(0);
         @(negedge mclk); #5 sample(1);
      end
   end

   // ---------------- driver ----------------
   task automatic step(input int n);
      repeat (n) @(posedge mclk);
      #2;
   endtask

   task automatic drain();
      while (qb.size() != 0 || qw.size() != 0) @(posedge mclk);
   endtask

   task automatic run_cfg(input int s, input int l, input bit b, input bit w,
                          input string tb_, input string tw_);
      int unsigned leff;
      chk_ph = 0;
      step(1);
      rst = 1; bdiv = 6'(s); wdiv = 6'(l); bp = b; wp = w;
      step(3);
      rst = 0;
      chk_ph = 1;
      @(w_tog); @(w_tog);
      tag_b = tb_; tag_w = tw_;
      leff = (l == 0) ? 1 : l;
      repeat (4) qb.push_back(s + 1);
      repeat (3) qw.push_back(2 * (s + 1) * leff);
      drain();
   endtask

   initial begin
      // R7: outputs low while reset held from start
      step(4);
      check(bclk == 0, "R7", bclk, 0);
      check(ws == 0, "R7", ws, 0);

      run_cfg(3, 16, 1, 1, "R1", "R8");   // 256-cycle word period
      run_cfg(7, 8, 0, 0, "R1", "R8");
      run_cfg(1, 32, 1, 0, "R1", "R8");
      run_cfg(0, 1, 0, 1, "R1", "R2");
      run_cfg(63, 3, 1, 1, "R1", "R2");
      run_cfg(2, 0, 1, 1, "R1", "R5");    // zero word divider acts as one
      run_cfg(2, 1, 0, 0, "R1", "R5");    // reference timing for one

      // R6: bit divider change mid half-period
      run_cfg(5, 2, 1, 1, "R1", "R2");
      @(b_tog);
      tag_b = "R6";
      qb.push_back(6); qb.push_back(3);
      step(2);
      bdiv = 6'd2;
      drain();

      // R6: word divider change mid half-period
      run_cfg(1, 4, 1, 1, "R1", "R2");
      @(w_tog);
      tag_w = "R6";
      qw.push_back(16); qw.push_back(8);
      step(2);
      wdiv = 6'd2;
      drain();

      // R7: reset in the middle of running
      run_cfg(4, 5, 1, 1, "R1", "R2");
      @(b_tog);
      step(2);
      rst = 1;
      step(1);
      #3;
      check(bclk == 0, "R7", bclk, 0);
      check(ws == 0, "R7", ws, 0);
      step(5);
      check(bclk == 0 && ws == 0, "R7", {bclk, ws}, 0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(20ns * 150000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule